// File: doc/BRIEF.md
# Diagnostic RAM Test Controller

This block holds a small diagnostic control and status register and the test path into a 34-bit-wide working RAM that the register controls. Software uses it for three things. It can lift write protection on other registers of the chip through a global write-enable output. It can choose which busy acknowledge code the receiver sends. It can read two bus idle-gap flags that a separate detector supplies.

The main feature is a RAM test mode. The mode is on when both the RAM-test bit and the register-write bit are set. While it is on, every host access to the fixed window offset 80h reaches the RAM word that an internal pointer selects, and the pointer then moves on by one, wrapping after the last word. On a write, the host data fills bits 31:0, bit 32 is written as zero, and bit 33 takes the value of the register's control-bit field. On a read, the word's top two bits are compared with {control bit, 0}, and any difference sets a sticky error flag. Writing the address-clear bit returns the pointer to word 0 and clears the error flag. The address-clear bit then drops by itself.

A sequencer with three states serves host reads. `ST_IDLE` accepts accesses. `ST_RAM_LATCH` is the cycle in which the RAM presents a word that was requested in the previous cycle. `ST_REPLY` drives `host_rvalid` for one cycle. The transitions are:
- `ST_IDLE`→`ST_RAM_LATCH` on a test-mode window read.
- `ST_IDLE`→`ST_REPLY` on any other read.
- `ST_RAM_LATCH`→`ST_REPLY` always.
- `ST_REPLY`→`ST_IDLE` always.

Writes complete in `ST_IDLE`.

Top module: `diag_test_ctrl`

Register layout at offset 20h:

| Bit | Field |
|---|---|
| 0 | snoop enable |
| 1 | busy select |
| 2 | arbitration-reset gap (status) |
| 3 | fair gap (status) |
| 4 | register write enable |
| 5 | address clear |
| 6 | control bit |
| 7 | control error (status) |
| 8 | RAM test |

All other bits read as zero.

## Requirements
- R1: After reset every register bit reads 0, `ram_addr` is 0, `reg_wr_en` and `snoop_en` are 0, and `busy_ack_code` is the busy-A code 4'h5.
- R2: A write to 20h always updates bit 0 and bit 4. Bits 1, 5, 6 and 8 are updated only if bit 4 was already set before that write. Bits 2, 3 and 7 are never written by the host.
- R3: Register bits 2 and 3 return the `arb_gap_idle` and `fair_gap_idle` inputs at the time of the read.
- R4: `busy_ack_code` is 4'h6 (busy-B) when bit 1 is set and 4'h5 (busy-A) when it is clear.
- R5: RAM test mode is on only when bit 8 and bit 4 are both set. Outside test mode, a window write leaves the RAM unchanged, a window read returns 0, and `ram_addr` does not move.
- R6: A write of 1 to bit 5, when permitted by R2, sets `ram_addr` to 0 and clears bit 7. Bit 5 reads 1 for one cycle and then reads 0.
- R7: A test-mode write to 80h stores {bit 6, 1'b0, host data} in the RAM word at `ram_addr`, then increments `ram_addr`.
- R8: A test-mode read of 80h returns bits 31:0 of the word at `ram_addr` with `host_rvalid` two cycles after the request. It then increments `ram_addr`, which wraps from 63 to 0.
- R9: A test-mode read sets bit 7 if RAM bit 33 differs from bit 6 or RAM bit 32 is 1. Bit 7 then stays set until an address clear or a reset.
- R10: A read of any address other than 80h in test mode returns `host_rvalid` one cycle after the request. The data is the register value at 20h and 0 elsewhere. `host_rvalid` never lasts more than one cycle.
- R11: `reg_wr_en` follows bit 4 and `snoop_en` follows bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle |
| host_wr | input | 1 | Access is a write |
| host_rd | input | 1 | Access is a read |
| host_addr | input | 8 | Byte offset of the access |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one-cycle pulse |
| ram_addr | output | 6 | RAM word pointer |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe; data expected one cycle later |
| ram_wdata | output | 34 | RAM write word |
| ram_rdata | input | 34 | RAM read word |
| arb_gap_idle | input | 1 | Bus idle for an arbitration-reset gap |
| fair_gap_idle | input | 1 | Bus idle for a fair (subaction) gap |
| reg_wr_en | output | 1 | Global write enable for other registers |
| snoop_en | output | 1 | Receive-all-packets enable |
| busy_ack_code | output | 4 | Busy acknowledge code to send |

## Verification
The assertions rely on three properties of the host's behaviour. It never asserts read and write in the same access. It starts no new access while a read is still waiting for `host_rvalid`. It leaves at least one idle cycle after a write to 20h, so that the address-clear pulse can fall. They also rely on the RAM returning data one cycle after `ram_re`. The bench keeps within these limits: every write task ends with an idle cycle, every read task waits for `host_rvalid` before it returns, and the RAM model has exactly one cycle of read latency.

// File: rtl/diag_test_pkg.sv
package diag_test_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RAM_LATCH = 2'd1,
        ST_REPLY     = 2'd2
    } seq_state_t;

    localparam int B_SNOOP = 0;
    localparam int B_BUSY  = 1;
    localparam int B_ARB   = 2;
    localparam int B_FAIR  = 3;
    localparam int B_RW    = 4;
    localparam int B_CLR   = 5;
    localparam int B_CTL   = 6;
    localparam int B_ERR   = 7;
    localparam int B_TEST  = 8;
    localparam int CSR_BITS = 9;

    typedef struct packed {
        logic ram_test;
        logic ctl_err;
        logic ctl_bit;
        logic addr_clr;
        logic reg_rw;
        logic busy_sel;
        logic snoop;
    } csr_fields_t;

endpackage

// File: rtl/diag_csr.sv
module diag_csr
    import diag_test_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_hit,
    input  logic [CSR_BITS-1:0] wbits,
    input  logic                err_set,
    output csr_fields_t         fld,
    output logic                clr_req
);

    csr_fields_t q;
    logic        wr_priv;

    // protected fields need the write-enable bit already stored
    assign wr_priv = wr_hit & q.reg_rw;
    assign clr_req = wr_priv & wbits[B_CLR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (wr_hit) begin
                q.snoop  <= wbits[B_SNOOP];
                q.reg_rw <= wbits[B_RW];
            end
            if (wr_priv) begin
                q.busy_sel <= wbits[B_BUSY];
                q.ctl_bit  <= wbits[B_CTL];
                q.ram_test <= wbits[B_TEST];
            end
            q.addr_clr <= clr_req;
            if (clr_req)
                q.ctl_err <= 1'b0;
            else if (err_set)
                q.ctl_err <= 1'b1;
        end
    end

    assign fld = q;

endmodule

// File: rtl/diag_ptr.sv
module diag_ptr #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (inc)
            q <= (q == LAST) ? '0 : q + 1'b1;
    end

    assign ptr = q;

endmodule

// File: rtl/diag_seq.sv
module diag_seq
    import diag_test_pkg::*;
#(
    parameter int          HOST_AW = 8,
    parameter int          HOST_DW = 32,
    parameter logic [7:0]  CSR_OFS = 8'h20,
    parameter logic [7:0]  WIN_OFS = 8'h80,
    localparam int         RAM_W   = HOST_DW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               test_mode,
    input  logic               ctl_bit,
    input  logic [HOST_DW-1:0] csr_value,
    input  logic [RAM_W-1:0]   ram_rdata,
    output logic               ram_we,
    output logic               ram_re,
    output logic               ptr_inc,
    output logic               csr_wr,
    output logic               err_set,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               host_rvalid,
    output logic               idle
);

    seq_state_t state, state_nx;
    logic       win_hit, csr_hit, rd_other;
    logic [HOST_DW-1:0] rdata_q;

    assign win_hit  = host_sel && (host_addr == HOST_AW'(WIN_OFS));
    assign csr_hit  = host_sel && (host_addr == HOST_AW'(CSR_OFS));
    assign idle     = (state == ST_IDLE);
    assign rd_other = idle && host_sel && host_rd && !ram_re;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ram_re)
                    state_nx = ST_RAM_LATCH;
                else if (host_sel && host_rd)
                    state_nx = ST_REPLY;
            end
            ST_RAM_LATCH: state_nx = ST_REPLY;
            ST_REPLY:     state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ram_we      = idle && win_hit && host_wr && test_mode;
        ram_re      = idle && win_hit && host_rd && test_mode;
        ptr_inc     = ram_we || ram_re;
        csr_wr      = idle && csr_hit && host_wr;
        host_rvalid = (state == ST_REPLY);
        err_set     = (state == ST_RAM_LATCH) &&
                      ((ram_rdata[RAM_W-1] != ctl_bit) || ram_rdata[RAM_W-2]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (state == ST_RAM_LATCH)
            rdata_q <= ram_rdata[HOST_DW-1:0];
        else if (rd_other)
            rdata_q <= csr_hit ? csr_value : '0;
    end

    assign host_rdata = rdata_q;

endmodule

// File: rtl/diag_test_ctrl.sv
module diag_test_ctrl
    import diag_test_pkg::*;
#(
    parameter int         HOST_AW    = 8,
    parameter int         HOST_DW    = 32,
    parameter int         RAM_DEPTH  = 64,
    parameter logic [7:0] CSR_OFS    = 8'h20,
    parameter logic [7:0] WIN_OFS    = 8'h80,
    parameter logic [3:0] ACK_BUSY_A = 4'h5,
    parameter logic [3:0] ACK_BUSY_B = 4'h6,
    localparam int        RAM_AW     = $clog2(RAM_DEPTH),
    localparam int        RAM_W      = HOST_DW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               host_rvalid,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic               ram_we,
    output logic               ram_re,
    output logic [RAM_W-1:0]   ram_wdata,
    input  logic [RAM_W-1:0]   ram_rdata,
    input  logic               arb_gap_idle,
    input  logic               fair_gap_idle,
    output logic               reg_wr_en,
    output logic               snoop_en,
    output logic [3:0]         busy_ack_code
);

    csr_fields_t        fld;
    logic               clr_req, err_set, ptr_inc, csr_wr, seq_idle, test_mode;
    logic [HOST_DW-1:0] csr_value;

    diag_csr u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (csr_wr),
        .wbits   (host_wdata[CSR_BITS-1:0]),
        .err_set (err_set),
        .fld     (fld),
        .clr_req (clr_req)
    );

    diag_ptr #(.DEPTH(RAM_DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_req),
        .inc   (ptr_inc),
        .ptr   (ram_addr)
    );

    diag_seq #(
        .HOST_AW (HOST_AW),
        .HOST_DW (HOST_DW),
        .CSR_OFS (CSR_OFS),
        .WIN_OFS (WIN_OFS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_sel    (host_sel),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .test_mode   (test_mode),
        .ctl_bit     (fld.ctl_bit),
        .csr_value   (csr_value),
        .ram_rdata   (ram_rdata),
        .ram_we      (ram_we),
        .ram_re      (ram_re),
        .ptr_inc     (ptr_inc),
        .csr_wr      (csr_wr),
        .err_set     (err_set),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .idle        (seq_idle)
    );

    assign test_mode = fld.ram_test & fld.reg_rw;

    always_comb begin
        csr_value         = '0;
        csr_value[B_SNOOP] = fld.snoop;
        csr_value[B_BUSY]  = fld.busy_sel;
        csr_value[B_ARB]   = arb_gap_idle;
        csr_value[B_FAIR]  = fair_gap_idle;
        csr_value[B_RW]    = fld.reg_rw;
        csr_value[B_CLR]   = fld.addr_clr;
        csr_value[B_CTL]   = fld.ctl_bit;
        csr_value[B_ERR]   = fld.ctl_err;
        csr_value[B_TEST]  = fld.ram_test;
    end

    assign ram_wdata     = {fld.ctl_bit, 1'b0, host_wdata};
    assign reg_wr_en     = fld.reg_rw;
    assign snoop_en      = fld.snoop;
    assign busy_ack_code = fld.busy_sel ? ACK_BUSY_B : ACK_BUSY_A;

endmodule

// File: rtl/diag_test_ctrl_chk.sv
module diag_test_ctrl_chk #(
    parameter int         HOST_AW   = 8,
    parameter int         HOST_DW   = 32,
    parameter int         RAM_DEPTH = 64,
    parameter logic [7:0] CSR_OFS   = 8'h20,
    localparam int        RAM_AW    = $clog2(RAM_DEPTH),
    localparam int        RAM_W     = HOST_DW + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_sel,
    input logic               host_wr,
    input logic [HOST_AW-1:0] host_addr,
    input logic [HOST_DW-1:0] host_wdata,
    input logic               host_rvalid,
    input logic [RAM_AW-1:0]  ram_addr,
    input logic               ram_we,
    input logic               ram_re,
    input logic [RAM_W-1:0]   ram_wdata,
    input logic               reg_rw,
    input logic               ram_test,
    input logic               ctl_bit,
    input logic               ctl_err,
    input logic               addr_clr,
    input logic               seq_idle
);

    logic csr_write, clr_write;
    assign csr_write = seq_idle && host_sel && host_wr && (host_addr == HOST_AW'(CSR_OFS));
    assign clr_write = csr_write && reg_rw && host_wdata[5];

    p_rw_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_write && !reg_rw) |=> (ram_test == $past(ram_test)));

    p_mode_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |-> (ram_test && reg_rw));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_write |=> (ram_addr == '0) && !ctl_err && addr_clr);

    p_self_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_clr && !clr_write) |=> !addr_clr);

    p_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_wdata[RAM_W-1] == ctl_bit) && !ram_wdata[RAM_W-2] &&
                   (ram_wdata[HOST_DW-1:0] == host_wdata));

    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |=>
            (ram_addr == (($past(ram_addr) == RAM_AW'(RAM_DEPTH - 1)) ? '0
                                                   : $past(ram_addr) + 1'b1)));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_err && !clr_write) |=> ctl_err);

    p_rvalid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

endmodule

bind diag_test_ctrl diag_test_ctrl_chk #(
    .HOST_AW   (HOST_AW),
    .HOST_DW   (HOST_DW),
    .RAM_DEPTH (RAM_DEPTH),
    .CSR_OFS   (CSR_OFS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_sel    (host_sel),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rvalid (host_rvalid),
    .ram_addr    (ram_addr),
    .ram_we      (ram_we),
    .ram_re      (ram_re),
    .ram_wdata   (ram_wdata),
    .reg_rw      (fld.reg_rw),
    .ram_test    (fld.ram_test),
    .ctl_bit     (fld.ctl_bit),
    .ctl_err     (fld.ctl_err),
    .addr_clr    (fld.addr_clr),
    .seq_idle    (seq_idle)
);

// File: tb/diag_test_ctrl_test.sv
module diag_test_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic [5:0]  ram_addr;
    logic        ram_we, ram_re;
    logic [33:0] ram_wdata;
    logic [33:0] ram_rdata;
    logic        arb_gap_idle = 1'b0, fair_gap_idle = 1'b0;
    logic        reg_wr_en, snoop_en;
    logic [3:0]  busy_ack_code;

    int checks = 0;
    int fails  = 0;

    logic [33:0] mem [64];

    always #4 clk = ~clk;

    diag_test_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .arb_gap_idle(arb_gap_idle), .fair_gap_idle(fair_gap_idle),
        .reg_wr_en(reg_wr_en), .snoop_en(snoop_en),
        .busy_ack_code(busy_ack_code)
    );

    // RAM model, one cycle read latency
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output int lat);
        @(negedge clk);
        host_sel = 1'b1; host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_sel = 1'b0; host_rd = 1'b0;
        lat = 1;
        while (!host_rvalid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        d = host_rdata;
    endtask

    function automatic logic [31:0] pat(input int i);
        return (32'(i) * 32'h9E37_79B1) ^ 32'h5A0F_C3A5;
    endfunction

    localparam logic [31:0] SN = 32'h001, BS = 32'h002, RW = 32'h010,
                            CL = 32'h020, CT = 32'h040, ER = 32'h080, TS = 32'h100;

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int lat;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        ram_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ram_addr == 0, "R1 ram_addr", 64'(ram_addr), 0);
        chk(!reg_wr_en && !snoop_en, "R1 enables", {reg_wr_en, snoop_en}, 0);
        chk(busy_ack_code == 4'h5, "R1 ack code", 64'(busy_ack_code), 5);
        rd(8'h20, d, lat);
        chk(d == 0, "R1 reg", 64'(d), 0);
        chk(lat == 1, "R10 reg read latency", 64'(lat), 1);

        // R2 protection: only bits 0 and 4 take effect
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, d, lat);
        chk(d == (SN | RW), "R2 protected write", 64'(d), 64'(SN | RW));
        chk(reg_wr_en && snoop_en, "R11 enables follow bits", {reg_wr_en, snoop_en}, 3);

        // R4 busy select, both values
        wr(8'h20, SN | RW | BS);
        chk(busy_ack_code == 4'h6, "R4 busy-B", 64'(busy_ack_code), 6);
        wr(8'h20, SN | RW);
        chk(busy_ack_code == 4'h5, "R4 busy-A", 64'(busy_ack_code), 5);

        // R3 sweep of gap inputs
        for (int g = 0; g < 4; g++) begin
            arb_gap_idle = g[0]; fair_gap_idle = g[1];
            rd(8'h20, d, lat);
            chk(d[3:2] == 2'(g), "R3 gap bits", 64'(d[3:2]), 64'(g));
        end
        arb_gap_idle = 1'b0; fair_gap_idle = 1'b0;

        // R10 unmapped address
        rd(8'h44, d, lat);
        chk(d == 0 && lat == 1, "R10 unmapped read", {32'(lat), d}, 64'h1_0000_0000);

        // R5 window outside test mode (ram_test clear)
        wr(8'h80, 32'hDEAD_BEEF);
        rd(8'h80, d, lat);
        chk(d == 0, "R5 read outside test", 64'(d), 0);
        chk(ram_addr == 0 && mem[0] == 0, "R5 no RAM effect", {26'(ram_addr), mem[0]}, 0);

        // R5 ram_test set but write enable cleared
        wr(8'h20, SN | RW | TS);
        wr(8'h20, SN | TS);
        rd(8'h20, d, lat);
        chk(d == (SN | TS), "R2 test bit kept", 64'(d), 64'(SN | TS));
        wr(8'h80, 32'h1234_5678);
        rd(8'h80, d, lat);
        chk(d == 0 && ram_addr == 0 && mem[0] == 0, "R5 half mode off",
            {26'(ram_addr), d}, 0);

        // R6 re-enable and clear
        wr(8'h20, SN | RW);
        wr(8'h20, SN | RW | TS | CL);
        rd(8'h20, d, lat);
        chk(d == (SN | RW | TS), "R6 clear self-drops", 64'(d), 64'(SN | RW | TS));
        chk(ram_addr == 0, "R6 pointer cleared", 64'(ram_addr), 0);

        // R7 write sweep, control bit changes every 16 words
        for (int i = 0; i < 64; i++) begin
            if (i % 16 == 0) wr(8'h20, SN | RW | TS | (i[4] ? CT : 32'h0));
            wr(8'h80, pat(i));
            if (i < 63)
                chk(ram_addr == 6'(i + 1), "R7 pointer step", 64'(ram_addr), 64'(i + 1));
        end
        chk(ram_addr == 0, "R8 pointer wraps", 64'(ram_addr), 0);
        for (int i = 0; i < 64; i++)
            chk(mem[i] == {i[4], 1'b0, pat(i)}, "R7 stored word", 64'(mem[i]),
                64'({i[4], 1'b0, pat(i)}));

        // R8 read sweep with matching control bit
        for (int i = 0; i < 64; i++) begin
            if (i % 16 == 0) wr(8'h20, SN | RW | TS | (i[4] ? CT : 32'h0));
            rd(8'h80, d, lat);
            chk(d == pat(i), "R8 read data", 64'(d), 64'(pat(i)));
            chk(lat == 2, "R8 read latency", 64'(lat), 2);
        end
        chk(ram_addr == 0, "R8 read wrap", 64'(ram_addr), 0);
        rd(8'h20, d, lat);
        chk(d[7] == 1'b0, "R9 no mismatch", 64'(d[7]), 0);

        // R9 mismatch then sticky
        wr(8'h20, SN | RW | TS | CT | CL);
        rd(8'h80, d, lat);
        rd(8'h20, d, lat);
        chk(d == (SN | RW | TS | CT | ER), "R9 error set", 64'(d),
            64'(SN | RW | TS | CT | ER));
        for (int i = 0; i < 16; i++) rd(8'h80, d, lat);
        rd(8'h20, d, lat);
        chk(d[7] == 1'b1, "R9 sticky", 64'(d[7]), 1);
        chk(ram_addr == 6'd17, "R8 pointer after reads", 64'(ram_addr), 17);
        wr(8'h20, SN | RW | TS | CT | ER);
        wr(8'h20, SN | RW | TS | CT | CL);
        rd(8'h20, d, lat);
        chk(d[7] == 1'b0 && ram_addr == 0, "R6 clear drops error",
            {26'(ram_addr), 32'(d[7])}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule